// File: doc/BRIEF.md
# Programmable Raster Line Interrupt

This block raises a CPU interrupt request at a chosen scan line of a video frame. A memory-mapped 8-bit target register holds the line number. The block counts scan lines from the frame-start pulse. Each horizontal sync pulse ends the current line. When the line that ends equals the target, the request line goes high. Software can rewrite the target within a frame, so it can take several interrupts in one frame, for example to change palettes or modes part-way down the screen.

A target of zero switches to the legacy periodic scheme. In that mode a 6-bit counter counts hsync pulses and raises the request on every 52nd one. An acknowledge in this mode also clears the counter's top bit. That lets an interrupt that is serviced late push the next one back.

The request is held by a two-state machine. `S_IDLE` moves to `S_PEND` on a fire event, which is either a line-compare hit or a legacy count hit. `S_PEND` returns to `S_IDLE` on an acknowledge that arrives with no fire event in the same cycle. In every other case each state holds.

Top module: `raster_irq_gen`

## Requirements
- R1: A write strobe with address 16'h6800 loads `wdata` into the target register. A write to any other address leaves the target and the interrupt behaviour unchanged.
- R2: After reset the target is 0, the legacy counter is 0, the line counter is 1 and `irq` is low.
- R3: With target T (1..255), `irq` goes high one clock after the hsync that ends line T. Line 1 is the line that begins at the frame-start pulse, and each hsync ends the current line and advances the count by one.
- R4: In compare mode, no interrupt is raised at a frame start alone, nor at the end of any line other than T.
- R5: With target 0, `irq` goes high one clock after every 52nd hsync. The count starts from reset, and the counter wraps to 0 when it fires.
- R6: Once high, `irq` stays high until `irq_ack`. It goes low one clock after an acknowledge that has no fire event in the same cycle.
- R7: In legacy mode, `irq_ack` clears bit 5 of the hsync counter, whether or not a request is pending. A count c of 32 or more therefore becomes c-32.
- R8: A new target applies from the next line end after the write. A write in the same cycle as an hsync leaves that line end compared against the old value.
- R9: Rewriting the target mid-frame to a later line produces a further interrupt in the same frame.
- R10: A fire event in the same cycle as `irq_ack` keeps `irq` high.
- R11: A frame-start pulse in the same cycle as an hsync restarts the line count at 1, and that cycle makes no line-compare event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| addr | input | 16 | CPU write address |
| wdata | input | 8 | CPU write data |
| hsync | input | 1 | One-cycle pulse at the end of each scan line |
| vsync | input | 1 | One-cycle frame-start pulse |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request, held until acknowledged |

## Verification
The compare path is swept over every target from 1 to 40 across 44-line frames. Each line end is checked, which tells a correct hit apart from an early (start-of-line) or an off-by-one hit. The legacy path runs three full 52-hsync periods, then an acknowledge at count 40. The moved next fire tells bit-5 clearing apart from a full counter reset or no effect. Directed patterns cover the following cases:
- writes to a neighbouring address;
- a write colliding with an hsync;
- a mid-frame rewrite;
- a fire colliding with an acknowledge;
- a frame start colliding with an hsync.

Each separates the intended priority from the alternatives.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_PEND = 1'b1
    } irq_state_e;
endpackage

// File: rtl/rirq_target_reg.sv
module rirq_target_reg #(
    parameter int ADDR_W = 16,
    parameter int LINE_W = 8,
    parameter logic [ADDR_W-1:0] TARGET_ADDR = 16'h6800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LINE_W-1:0] wdata,
    output logic [LINE_W-1:0] target
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            target <= '0;
        else if (wr_en && addr == TARGET_ADDR)
            target <= wdata;
    end
endmodule

// File: rtl/rirq_line_counter.sv
module rirq_line_counter #(
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              vsync,
    output logic [LINE_W-1:0] line
);
    localparam logic [LINE_W-1:0] FIRST_LINE = LINE_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            line <= FIRST_LINE;
        else if (vsync)
            line <= FIRST_LINE;
        else if (hsync)
            line <= line + LINE_W'(1);
    end
endmodule

// File: rtl/rirq_legacy_counter.sv
module rirq_legacy_counter #(
    parameter int CNT_W  = 6,
    parameter int PERIOD = 52
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic hsync,
    input  logic clr_top,
    output logic hit
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;

    assign hit = enable && hsync && (cnt == LAST);

    always_comb begin
        cnt_nxt = cnt;
        if (enable && hsync)
            cnt_nxt = (cnt == LAST) ? '0 : cnt + CNT_W'(1);
        if (clr_top)
            cnt_nxt[CNT_W-1] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= cnt_nxt;
    end
endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen
    import raster_irq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LINE_W = 8,
    parameter logic [ADDR_W-1:0] TARGET_ADDR = 16'h6800,
    parameter int LEGACY_CNT_W = 6,
    parameter int LEGACY_PERIOD = 52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LINE_W-1:0] wdata,
    input  logic              hsync,
    input  logic              vsync,
    input  logic              irq_ack,
    output logic              irq
);
    logic [LINE_W-1:0] target;
    logic [LINE_W-1:0] line;
    logic              legacy_mode;
    logic              legacy_hit;
    logic              compare_hit;
    logic              fire;

    irq_state_e state_q;
    irq_state_e state_d;

    rirq_target_reg #(
        .ADDR_W      (ADDR_W),
        .LINE_W      (LINE_W),
        .TARGET_ADDR (TARGET_ADDR)
    ) u_target (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .target (target)
    );

    rirq_line_counter #(
        .LINE_W (LINE_W)
    ) u_lines (
        .clk   (clk),
        .rst_n (rst_n),
        .hsync (hsync),
        .vsync (vsync),
        .line  (line)
    );

    assign legacy_mode = (target == '0);

    rirq_legacy_counter #(
        .CNT_W  (LEGACY_CNT_W),
        .PERIOD (LEGACY_PERIOD)
    ) u_legacy (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (legacy_mode),
        .hsync   (hsync),
        .clr_top (irq_ack && legacy_mode),
        .hit     (legacy_hit)
    );

    // Line end compare; a frame start in the same cycle suppresses it.
    assign compare_hit = !legacy_mode && hsync && !vsync && (line == target);
    assign fire        = compare_hit || legacy_hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (fire)              state_d = S_PEND;
            S_PEND: if (irq_ack && !fire)  state_d = S_IDLE;
            default:                       state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            S_PEND:  irq = 1'b1;
            default: irq = 1'b0;
        endcase
    end
endmodule

// File: rtl/raster_irq_gen_checker.sv
module raster_irq_gen_checker (
    input logic clk,
    input logic rst_n,
    input logic hsync,
    input logic irq_ack,
    input logic irq
);
    // R2: the cycle after reset is sampled, the request is low
    p_reset_low_r2: assert property (@(posedge clk)
        !rst_n |=> !irq);

    // R6: a pending request holds until acknowledged
    p_hold_until_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_ack |=> irq);

    // R6: an acknowledge with no line end drops the request
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq && irq_ack && !hsync |=> !irq);

    // R3: requests only rise after a line end
    p_rise_needs_hsync_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !irq && !hsync |=> !irq);

    // R10: a line end in the same cycle as an acknowledge may keep irq high, but never raises from nothing without hsync
    p_rise_only_from_hsync_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(hsync));
endmodule

bind raster_irq_gen raster_irq_gen_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hsync   (hsync),
    .irq_ack (irq_ack),
    .irq     (irq)
);

// File: tb/raster_irq_gen_bench.sv
`timescale 1ns/1ps
module raster_irq_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        hsync = 1'b0;
    logic        vsync = 1'b0;
    logic        irq_ack = 1'b0;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    raster_irq_gen u_raster_irq_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .hsync   (hsync),
        .vsync   (vsync),
        .irq_ack (irq_ack),
        .irq     (irq)
    );

    task automatic check(input bit exp, input string tag);
        n_chk++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL %s: irq=%0b expected=%0b at %0t", tag, irq, exp, $time);
        end
    endtask

    // Drive one cycle of inputs from a negedge; returns at the next negedge.
    task automatic tick(input bit hs, input bit vs, input bit ak,
                        input bit we, input logic [15:0] a, input logic [7:0] d);
        hsync = hs; vsync = vs; irq_ack = ak; wr_en = we; addr = a; wdata = d;
        @(negedge clk);
        hsync = 1'b0; vsync = 1'b0; irq_ack = 1'b0; wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_target(input logic [7:0] v);
        tick(0, 0, 0, 1, 16'h6800, v);
    endtask

    task automatic frame_start();
        tick(0, 1, 0, 0, '0, '0);
    endtask

    task automatic line_end();
        tick(1, 0, 0, 0, '0, '0);
    endtask

    task automatic ack();
        tick(0, 0, 1, 0, '0, '0);
    endtask

    initial begin
        #2ms;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        bit f;
        @(negedge clk);
        do_reset();
        check(1'b0, "R2 reset irq low");

        // R5 legacy sweep over three periods from reset
        cnt = 0;
        for (int i = 1; i <= 156; i++) begin
            f = (cnt == 51);
            cnt = f ? 0 : cnt + 1;
            line_end();
            check(f, "R5 legacy period 52");
            if (f) begin
                ack();
                check(1'b0, "R6 ack clears legacy irq");
            end
        end

        // R7 ack at count 40 clears bit 5 -> count 8, next fire after 44 hsyncs
        for (int i = 0; i < 40; i++) begin
            line_end();
            check(1'b0, "R7 count up to 40");
        end
        cnt = 40;
        ack();
        cnt = cnt & 31;
        check(1'b0, "R7 ack while idle");
        for (int i = 1; i <= 44; i++) begin
            f = (cnt == 51);
            cnt = f ? 0 : cnt + 1;
            line_end();
            check(f, "R7 fire moved by bit-5 clear");
        end
        ack();

        // R1 write to a neighbouring address is ignored (still legacy, no fire)
        do_reset();
        tick(0, 0, 0, 1, 16'h6801, 8'd3);
        frame_start();
        for (int ln = 1; ln <= 10; ln++) begin
            line_end();
            check(1'b0, "R1 other address ignored");
        end

        // R3/R4 compare sweep over targets 1..40
        do_reset();
        for (int t = 1; t <= 40; t++) begin
            write_target(8'(t));
            frame_start();
            check(1'b0, "R4 no irq on frame start");
            for (int ln = 1; ln <= 44; ln++) begin
                line_end();
                check(ln == t, "R3/R4 fire at end of target line");
                if (ln == t) begin
                    tick(0, 0, 0, 0, '0, '0);
                    check(1'b1, "R6 irq held without ack");
                    ack();
                    check(1'b0, "R6 ack clears irq");
                end
            end
        end

        // R8 write colliding with hsync: the line end sees the old value
        write_target(8'd4);
        frame_start();
        line_end(); line_end();
        tick(1, 0, 0, 1, 16'h6800, 8'd3);
        check(1'b0, "R8 line 3 compared with old target 4");
        line_end();
        check(1'b0, "R8 line 4 compared with new target 3");
        frame_start();
        line_end(); line_end(); line_end();
        check(1'b1, "R8 new target 3 applies next frame");
        ack();

        // R9 mid-frame rewrite gives a second interrupt
        write_target(8'd2);
        frame_start();
        line_end();
        line_end();
        check(1'b1, "R9 first irq at line 2");
        ack();
        write_target(8'd6);
        for (int ln = 3; ln <= 8; ln++) begin
            line_end();
            check(ln == 6, "R9 second irq at line 6");
            if (ln == 6) ack();
        end

        // R10 fire together with ack keeps irq high
        write_target(8'd2);
        frame_start();
        line_end(); line_end();
        check(1'b1, "R10 pending from line 2");
        write_target(8'd3);
        tick(1, 0, 1, 0, '0, '0);
        check(1'b1, "R10 fire wins over ack");
        ack();
        check(1'b0, "R10 later ack clears");

        // R11 frame start with hsync: count restarts, no compare
        write_target(8'd1);
        frame_start();
        line_end(); ack();
        tick(1, 1, 0, 0, '0, '0);
        check(1'b0, "R11 no compare on frame start cycle");
        line_end();
        check(1'b1, "R11 line 1 ends after restart");
        ack();

        // R1 a second address leaves a programmed target intact
        tick(0, 0, 0, 1, 16'h6900, 8'd9);
        frame_start();
        line_end();
        check(1'b1, "R1 target 1 unchanged by other write");
        ack();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule